// File: doc/BRIEF.md
# UART receive character timeout detector

This block raises the character-timeout condition for the receive side of a UART that buffers incoming characters in a FIFO. It watches the FIFO occupancy together with pulses marking each character stored by the serial receiver and each character taken by the CPU. When characters sit in the FIFO and none arrive or leave for four character times, it raises a pending flag. The interrupt identification logic uses this flag to tell software that a few leftover characters are waiting below the trigger level.

One character time is the length of one serial frame in bits. That is a start bit, 5 to 8 data bits, an optional parity bit, and one or two stop bits. Time is measured in ticks of the 16x oversampling baud clock, so the window is 64 ticks for each frame bit. A push or a pop restarts the window. A CPU read clears a pending timeout. All pins are plain control and status signals, and none of them uses a handshake.

Top module: `rx_char_timeout`

## Requirements
- R1: With `fifo_mode_en`=1 and `rx_nonempty`=1, and no `rx_push` or `rx_pop`, `timeout_pending` rises on the clock edge that samples the W-th `baud_tick16` since the window started, where W = 64 x frame bits. It is still 0 after the edge of tick W-1.
- R2: Frame bits = 1 + data bits + `parity_en` + (`two_stop` ? 2 : 1). `word_len` encodes data bits as 0→5, 1→6, 2→7, 3→8, so W ranges from 448 (5 data, no parity, 1 stop) to 768 (8 data, parity, 2 stops).
- R3: A cycle with `rx_pop`=1 clears `timeout_pending` at that edge and restarts the window.
- R4: A push or pop starts a new window from zero. No timeout is raised until W ticks after the last such event, however many ticks came before it.
- R5: While `fifo_mode_en`=0, `timeout_pending` is 0. Dropping the mode clears a pending timeout at the next edge.
- R6: Once set, `timeout_pending` stays 1 through further ticks until a pop, a push, an empty FIFO or non-FIFO mode.
- R7: While `rx_nonempty`=0 the window counter is held at zero and `timeout_pending` is 0. After reset the flag is 0. The window starts from zero in the first cycle the FIFO is seen non-empty.
- R8: Only cycles with `baud_tick16`=1 advance the window. Clock cycles without a tick do not count.
- R9: A cycle with `rx_push`=1 clears `timeout_pending` at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_mode_en | input | 1 | 1 = receive FIFO enabled; 0 = single-buffer mode |
| rx_nonempty | input | 1 | Receive FIFO holds at least one character |
| rx_push | input | 1 | One-cycle pulse per character written into the FIFO |
| rx_pop | input | 1 | One-cycle pulse per character read by the CPU |
| baud_tick16 | input | 1 | One-cycle tick at 16x the baud rate |
| word_len | input | 2 | Data bits per character (0→5 … 3→8) |
| parity_en | input | 1 | Frame carries a parity bit |
| two_stop | input | 1 | Frame carries two stop bits |
| timeout_pending | output | 1 | Character timeout is pending |

## Verification
The bench checks the exact edge at which the flag rises for four frame formats, including the shortest and the longest. A wrong bit count or an off-by-one comparison would show up there as an early or late flag. Ticks are spaced every third cycle, which catches a design that counts clock cycles instead of baud ticks. The window is restarted part way through by a push and by a pop; a design that does not restart would fire early. The bench also checks that the flag persists after expiry, and that it is held clear when the FIFO is empty, when FIFO mode is off, and after a CPU read. A flag that drops by itself, or that is set in single-buffer mode, would fail these checks.

// File: rtl/rx_to_pkg.sv
package rx_to_pkg;

  typedef enum logic [1:0] {
    WLEN_5 = 2'd0,
    WLEN_6 = 2'd1,
    WLEN_7 = 2'd2,
    WLEN_8 = 2'd3
  } wlen_e;

  localparam int unsigned FRAME_BITS_MAX = 12;
  localparam int unsigned FRAME_BITS_W   = 4;

  // start + data + parity + stop bits in one serial frame
  function automatic logic [FRAME_BITS_W-1:0] frame_bits(
    input wlen_e wl,
    input logic  par,
    input logic  two_stop
  );
    logic [FRAME_BITS_W-1:0] b;
    b = 4'd6 + {2'b00, wl};
    b = b + {3'b000, par};
    b = b + (two_stop ? 4'd2 : 4'd1);
    return b;
  endfunction

endpackage

// File: rtl/rxto_window_len.sv
module rxto_window_len
  import rx_to_pkg::*;
#(
  parameter int unsigned OVS   = 16,
  parameter int unsigned CHARS = 4,
  parameter int unsigned CNT_W = 10
) (
  input  logic [1:0]       word_len,
  input  logic             parity_en,
  input  logic             two_stop,
  output logic [CNT_W-1:0] window
);
  localparam int unsigned SCALE = OVS * CHARS;

  logic [FRAME_BITS_W-1:0] bits;
  assign bits = frame_bits(wlen_e'(word_len), parity_en, two_stop);

  generate
    if ((SCALE & (SCALE - 1)) == 0) begin : g_shift
      localparam int unsigned SH = $clog2(SCALE);
      assign window = CNT_W'(bits) << SH;
    end else begin : g_mult
      localparam logic [CNT_W-1:0] SCALE_V = CNT_W'(SCALE);
      assign window = CNT_W'(bits) * SCALE_V;
    end
  endgenerate

endmodule

// File: rtl/rxto_char_timer.sv
module rxto_char_timer #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             restart,
  input  logic             tick,
  input  logic [CNT_W-1:0] window,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!arm || restart) begin
      cnt_q <= '0;
    end else if (tick && (cnt_q < window)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // fires once, on the tick that completes the window; count then saturates
  assign expire = arm && !restart && tick && (window != '0) &&
                  (cnt_q == window - 1'b1);

endmodule

// File: rtl/rxto_pending.sv
module rxto_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic pending
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pending <= 1'b0;
    else if (clr) pending <= 1'b0;
    else if (set) pending <= 1'b1;
  end
endmodule

// File: rtl/rx_char_timeout.sv
module rx_char_timeout
  import rx_to_pkg::*;
#(
  parameter int unsigned OVS   = 16,
  parameter int unsigned CHARS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_mode_en,
  input  logic       rx_nonempty,
  input  logic       rx_push,
  input  logic       rx_pop,
  input  logic       baud_tick16,
  input  logic [1:0] word_len,
  input  logic       parity_en,
  input  logic       two_stop,
  output logic       timeout_pending
);
  localparam int unsigned WIN_MAX = FRAME_BITS_MAX * OVS * CHARS;
  localparam int unsigned CNT_W   = $clog2(WIN_MAX + 1);

  logic [CNT_W-1:0] window;
  logic             arm;
  logic             restart;
  logic             expire;

  assign arm     = fifo_mode_en && rx_nonempty;
  assign restart = rx_push || rx_pop;

  rxto_window_len #(.OVS(OVS), .CHARS(CHARS), .CNT_W(CNT_W)) u_len (
    .word_len (word_len),
    .parity_en(parity_en),
    .two_stop (two_stop),
    .window   (window)
  );

  rxto_char_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm    (arm),
    .restart(restart),
    .tick   (baud_tick16),
    .window (window),
    .expire (expire)
  );

  rxto_pending u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (expire),
    .clr    (!arm || restart),
    .pending(timeout_pending)
  );

endmodule

// File: rtl/rx_char_timeout_chk.sv
module rx_char_timeout_chk (
  input logic clk,
  input logic rst_n,
  input logic fifo_mode_en,
  input logic rx_nonempty,
  input logic rx_push,
  input logic rx_pop,
  input logic baud_tick16,
  input logic timeout_pending
);
  // R1 / R8: a rise needs an idle, armed tick cycle just before
  p_rise_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_pending) |->
      $past(baud_tick16 && fifo_mode_en && rx_nonempty && !rx_push && !rx_pop));

  p_pop_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |=> !timeout_pending);

  p_mode_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode_en |=> !timeout_pending);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_pending && fifo_mode_en && rx_nonempty && !rx_push && !rx_pop)
      |=> timeout_pending);

  p_empty_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_nonempty |=> !timeout_pending);

  p_push_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> !timeout_pending);

endmodule

bind rx_char_timeout rx_char_timeout_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .fifo_mode_en   (fifo_mode_en),
  .rx_nonempty    (rx_nonempty),
  .rx_push        (rx_push),
  .rx_pop         (rx_pop),
  .baud_tick16    (baud_tick16),
  .timeout_pending(timeout_pending)
);

// File: tb/rx_char_timeout_tb_top.sv
`timescale 1ns/1ps
module rx_char_timeout_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, fifo_mode_en, rx_nonempty, rx_push, rx_pop, baud_tick16;
  logic [1:0] word_len;
  logic       parity_en, two_stop, timeout_pending;

  rx_char_timeout dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_mode_en(fifo_mode_en),
    .rx_nonempty(rx_nonempty), .rx_push(rx_push), .rx_pop(rx_pop),
    .baud_tick16(baud_tick16), .word_len(word_len), .parity_en(parity_en),
    .two_stop(two_stop), .timeout_pending(timeout_pending)
  );

  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 0;
  string q_tag[$];
  bit    q_exp[$];

  // expectation for the output after the next rising edge
  task automatic expect_out(string tag, bit e);
    q_tag.push_back(tag);
    q_exp.push_back(e);
  endtask

  // monitor: compares one queued item per edge
  always @(posedge clk) begin
    string t;
    bit    e;
    #2;
    if (q_tag.size() > 0) begin
      t = q_tag.pop_front();
      e = q_exp.pop_front();
      n_chk++;
      if (timeout_pending !== e) begin
        n_fail++;
        $display("FAIL %s: timeout_pending=%b expected %b", t, timeout_pending, e);
      end
    end
  end

  function automatic int win_ticks(int wl, int par, int stp);
    return (1 + (5 + wl) + par + (stp ? 2 : 1)) * 16 * 4;
  endfunction

  task automatic idle_to_expiry(int w, int per, string tag);
    int t = 0;
    int i = 0;
    while (t < w) begin
      rx_push = 0; rx_pop = 0;
      baud_tick16 = (i % per == 0);
      if (baud_tick16) begin
        t++;
        if (t == w - 1) expect_out({tag, " not before W"}, 1'b0);
        if (t == w)     expect_out({tag, " at W"}, 1'b1);
      end
      i++;
      @(negedge clk);
    end
    baud_tick16 = 0;
  endtask

  task automatic idle_ticks(int n, string tag, bit e);
    for (int i = 0; i < n; i++) begin
      rx_push = 0; rx_pop = 0; baud_tick16 = 1;
      if (i == n - 1) expect_out(tag, e);
      @(negedge clk);
    end
    baud_tick16 = 0;
  endtask

  task automatic pulse(bit is_push, string tag);
    rx_push = is_push; rx_pop = !is_push; baud_tick16 = 1;
    expect_out(tag, 1'b0);
    @(negedge clk);
    rx_push = 0; rx_pop = 0; baud_tick16 = 0;
  endtask

  task automatic set_fmt(int wl, int par, int stp);
    word_len = 2'(wl); parity_en = par[0]; two_stop = stp[0];
  endtask

  initial begin
    rst_n = 0; fifo_mode_en = 1; rx_nonempty = 0; rx_push = 0; rx_pop = 0;
    baud_tick16 = 0; set_fmt(3, 0, 0);
    @(negedge clk);
    expect_out("R7 reset value", 1'b0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R7: empty FIFO never times out
    idle_ticks(900, "R7 empty FIFO", 1'b0);
    rx_nonempty = 1;
    idle_to_expiry(win_ticks(3, 0, 0), 1, "R7/R1 8N1 window from non-empty");

    idle_ticks(60, "R6 flag held after expiry", 1'b1);
    pulse(1'b0, "R3 pop clears");
    idle_to_expiry(win_ticks(3, 0, 0), 1, "R3/R4 restart after pop");
    pulse(1'b1, "R9 push clears");

    // R4: push part way through restarts window
    idle_ticks(300, "R4 no early expiry", 1'b0);
    pulse(1'b1, "R4 push mid window");
    idle_to_expiry(win_ticks(3, 0, 0), 1, "R4 full window after push");
    pulse(1'b0, "R4 pop clears");
    idle_ticks(500, "R4 no early expiry 2", 1'b0);
    pulse(1'b0, "R4 pop mid window");
    idle_to_expiry(win_ticks(3, 0, 0), 1, "R4 full window after pop");

    // R2: frame formats
    set_fmt(0, 0, 0); pulse(1'b1, "R2 push");
    idle_to_expiry(win_ticks(0, 0, 0), 1, "R2 5N1");
    set_fmt(1, 1, 0); pulse(1'b1, "R2 push");
    idle_to_expiry(win_ticks(1, 1, 0), 1, "R2 6P1");
    set_fmt(3, 1, 1); pulse(1'b1, "R2 push");
    idle_to_expiry(win_ticks(3, 1, 1), 1, "R2 8P2");
    set_fmt(2, 0, 1); pulse(1'b1, "R2 push");
    idle_to_expiry(win_ticks(2, 0, 1), 1, "R2 7N2");

    // R8: sparse ticks
    set_fmt(3, 0, 0); pulse(1'b1, "R8 push");
    idle_to_expiry(win_ticks(3, 0, 0), 3, "R8 ticks every third cycle");

    // R5: non-FIFO mode
    fifo_mode_en = 0;
    idle_ticks(1, "R5 mode off clears", 1'b0);
    idle_ticks(900, "R5 no timeout in non-FIFO mode", 1'b0);
    fifo_mode_en = 1;
    idle_to_expiry(win_ticks(3, 0, 0), 1, "R5 FIFO mode back on");
    rx_nonempty = 0;
    idle_ticks(1, "R7 empty clears flag", 1'b0);

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule